// File: doc/BRIEF.md
# Three-Slot Micro-op Decode Steering

This block sits between an instruction queue and three decoders of unequal strength. Each cycle it inspects the oldest three queued instructions. Each instruction carries a valid bit, a micro-op count (one or more) and a byte length. The block decides which of them enter decode this cycle. Slot 0 feeds the complex decoder, which produces up to four micro-ops per cycle. Slots 1 and 2 feed simple decoders that accept only single-micro-op instructions. The block reports a grant per slot, how many instructions leave the queue (0 to 3) and how many micro-ops are emitted (at most six).

Grouping is strictly in program order. The block never skips an instruction to grant a younger one. An instruction whose length exceeds seven bytes is decoded by itself. An instruction that expands to more than four micro-ops is fed through the complex decoder in chunks of four over several cycles. While this happens the block raises `busy` and reports zero consumed. The queue must then hold all three slots unchanged.

The block has two states. `ST_GROUP` is normal grouping. `ST_EXPAND` covers the second and later chunks of a long expansion. The state moves `ST_GROUP -> ST_EXPAND` when a valid head instruction has more than four micro-ops, because its first chunk of four is emitted in that cycle. It stays `ST_EXPAND -> ST_EXPAND` while more than four micro-ops remain. It returns `ST_EXPAND -> ST_GROUP` on the final chunk, which emits the remaining one to four micro-ops. All outputs are combinational from the current state and the slot inputs.

Top module: `uop_decode_steer`

## Requirements
- R1: After reset the block is in normal grouping. With no valid slot, `slot_grant` is 000, `consumed` is 0, `uops_out` is 0 and `busy` is 0.
- R2: `consumed` never exceeds 3 and `uops_out` never exceeds 6.
- R3: When slot 0 holds a valid instruction of one to four micro-ops in normal grouping, slot 0 is granted (`slot_grant[0]`=1). The head instruction is counted in `consumed` and its micro-op count is added to `uops_out`.
- R4: Slot 1 or slot 2 is granted only for an instruction of exactly one micro-op. Grants are in order: slot 2 is never granted unless slot 1 is granted, and slot 1 is never granted unless slot 0 is granted.
- R5: If the slot 0 instruction is longer than seven bytes, slot 0 alone is granted. If the slot 1 instruction is longer than seven bytes, neither slot 1 nor slot 2 is granted. If only the slot 2 instruction is longer than seven bytes, slot 2 alone is refused.
- R6: A head instruction of more than four micro-ops emits four micro-ops per cycle in slot 0 alone. During each such non-final cycle `slot_grant`=001, `consumed`=0 and `busy`=1.
- R7: The final chunk of a long expansion emits the remaining micro-ops, one to four. In the same cycle it may be joined by qualifying single-micro-op instructions in slots 1 and 2, and `consumed` then counts the long instruction too.
- R8: Whenever `busy` is 0, `consumed` equals the number of granted slots. `uops_out` equals the slot 0 chunk plus one for each granted follower.
- R9: A slot whose valid bit is 0 is never granted. A valid-0 slot 1 blocks slot 2. An invalid slot 0 in normal grouping grants nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_valid | input | 3 | Valid bit per slot, bit 0 is the oldest |
| slot_uops | input | 3*UCNT_W | Micro-op count per slot, slot k at bits [k*UCNT_W +: UCNT_W] |
| slot_len | input | 3*LEN_W | Byte length per slot, slot k at bits [k*LEN_W +: LEN_W] |
| slot_grant | output | 3 | Slot k enters decode this cycle |
| consumed | output | 2 | Instructions removed from the queue this cycle |
| uops_out | output | 3 | Micro-ops emitted this cycle |
| busy | output | 1 | A long expansion continues next cycle; hold the slots |

## Verification
Every result is combinational, so the grants, counts and busy flag for a set of slot inputs are due in the same cycle the inputs are applied, before the next rising edge. Only the state register and the remaining-micro-op count carry over an edge. A long expansion therefore shows its next chunk in the cycle after each busy cycle. The driver applies inputs on the falling edge and queues the expected result for that cycle. The monitor compares one nanosecond later, well before the edge that advances the expansion. The bench tracks the remaining count from the requirements, so each multi-cycle sequence is checked chunk by chunk.

// File: rtl/uop_steer_pkg.sv
`timescale 1ns/1ps
package uop_steer_pkg;

    typedef enum logic {
        ST_GROUP  = 1'b0,
        ST_EXPAND = 1'b1
    } steer_state_e;

    localparam int NUM_SLOTS = 3;

endpackage

// File: rtl/steer_slot_qual.sv
`timescale 1ns/1ps
// Per-slot qualification: length limit and single-micro-op test.
module steer_slot_qual #(
    parameter int NSLOT   = 3,
    parameter int UCNT_W  = 5,
    parameter int LEN_W   = 4,
    parameter int MAX_LEN = 7
) (
    input  logic [NSLOT-1:0]        valid,
    input  logic [NSLOT*UCNT_W-1:0] uops_flat,
    input  logic [NSLOT*LEN_W-1:0]  len_flat,
    output logic [NSLOT-1:0]        len_ok,
    output logic [NSLOT-1:0]        simple_ok
);
    localparam logic [LEN_W-1:0]  LEN_LIM = LEN_W'(MAX_LEN);
    localparam logic [UCNT_W-1:0] ONE_UOP = UCNT_W'(1);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [UCNT_W-1:0] cnt;
        logic [LEN_W-1:0]  len;
        assign cnt          = uops_flat[g*UCNT_W +: UCNT_W];
        assign len          = len_flat[g*LEN_W +: LEN_W];
        assign len_ok[g]    = (len <= LEN_LIM);
        assign simple_ok[g] = valid[g] && (cnt == ONE_UOP) && len_ok[g];
    end

endmodule

// File: rtl/steer_seq_ctrl.sv
`timescale 1ns/1ps
// Sequencer for the complex decoder: splits long expansions into chunks.
module steer_seq_ctrl
    import uop_steer_pkg::*;
#(
    parameter int UCNT_W    = 5,
    parameter int CPLX_UOPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic [UCNT_W-1:0] head_uops,
    output logic              head_active,
    output logic              head_final,
    output logic [UCNT_W-1:0] chunk_uops,
    output logic              busy
);
    localparam logic [UCNT_W-1:0] CHUNK = UCNT_W'(CPLX_UOPS);

    steer_state_e      state, state_n;
    logic [UCNT_W-1:0] rem, rem_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_GROUP;
            rem   <= '0;
        end else begin
            state <= state_n;
            rem   <= rem_n;
        end
    end

    always_comb begin
        state_n     = state;
        rem_n       = rem;
        head_active = 1'b0;
        head_final  = 1'b0;
        chunk_uops  = '0;
        unique case (state)
            ST_GROUP: begin
                if (head_valid) begin
                    head_active = 1'b1;
                    if (head_uops > CHUNK) begin
                        chunk_uops = CHUNK;
                        rem_n      = head_uops - CHUNK;
                        state_n    = ST_EXPAND;
                    end else begin
                        chunk_uops = head_uops;
                        head_final = 1'b1;
                    end
                end
            end
            ST_EXPAND: begin
                head_active = 1'b1;
                if (rem > CHUNK) begin
                    chunk_uops = CHUNK;
                    rem_n      = rem - CHUNK;
                end else begin
                    chunk_uops = rem;
                    head_final = 1'b1;
                    rem_n      = '0;
                    state_n    = ST_GROUP;
                end
            end
        endcase
        busy = head_active && !head_final;
    end

endmodule

// File: rtl/steer_group.sv
`timescale 1ns/1ps
// In-order grouping of the followers behind the slot 0 chunk.
module steer_group #(
    parameter int UCNT_W    = 5,
    parameter int CYCLE_CAP = 6,
    parameter int OUT_W     = 3,
    parameter int CNT_W     = 2
) (
    input  logic              head_active,
    input  logic              head_final,
    input  logic              head_len_ok,
    input  logic [UCNT_W-1:0] chunk_uops,
    input  logic [1:0]        follow_ok,
    output logic [2:0]        grant,
    output logic [CNT_W-1:0]  consumed,
    output logic [OUT_W-1:0]  uops_out
);
    localparam int SUM_W = UCNT_W + 2;
    localparam logic [SUM_W-1:0] CAP_L = SUM_W'(CYCLE_CAP);
    localparam logic [SUM_W-1:0] ONE_L = SUM_W'(1);
    localparam logic [SUM_W-1:0] TWO_L = SUM_W'(2);

    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] total;

    always_comb begin
        base     = SUM_W'(chunk_uops);
        grant[0] = head_active;
        grant[1] = head_active && head_final && head_len_ok && follow_ok[0]
                   && ((base + ONE_L) <= CAP_L);
        grant[2] = grant[1] && follow_ok[1] && ((base + TWO_L) <= CAP_L);
        total    = base + SUM_W'(grant[1]) + SUM_W'(grant[2]);
        uops_out = OUT_W'(total);
        if (head_final)
            consumed = CNT_W'(grant[0]) + CNT_W'(grant[1]) + CNT_W'(grant[2]);
        else
            consumed = '0;
    end

endmodule

// File: rtl/uop_decode_steer.sv
`timescale 1ns/1ps
module uop_decode_steer
    import uop_steer_pkg::*;
#(
    parameter int UCNT_W    = 5,
    parameter int LEN_W     = 4,
    parameter int MAX_LEN   = 7,
    parameter int CPLX_UOPS = 4,
    parameter int CYCLE_CAP = 6,
    localparam int OUT_W    = $clog2(CYCLE_CAP + 1),
    localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SLOTS-1:0]      slot_valid,
    input  logic [NUM_SLOTS*UCNT_W-1:0] slot_uops,
    input  logic [NUM_SLOTS*LEN_W-1:0]  slot_len,
    output logic [NUM_SLOTS-1:0]      slot_grant,
    output logic [CNT_W-1:0]          consumed,
    output logic [OUT_W-1:0]          uops_out,
    output logic                      busy
);
    logic [NUM_SLOTS-1:0] len_ok;
    logic [NUM_SLOTS-1:0] simple_ok;
    logic                 head_active;
    logic                 head_final;
    logic [UCNT_W-1:0]    chunk_uops;

    steer_slot_qual #(
        .NSLOT(NUM_SLOTS), .UCNT_W(UCNT_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)
    ) qual_i (
        .valid(slot_valid), .uops_flat(slot_uops), .len_flat(slot_len),
        .len_ok(len_ok), .simple_ok(simple_ok)
    );

    steer_seq_ctrl #(
        .UCNT_W(UCNT_W), .CPLX_UOPS(CPLX_UOPS)
    ) seq_i (
        .clk(clk), .rst_n(rst_n),
        .head_valid(slot_valid[0]), .head_uops(slot_uops[UCNT_W-1:0]),
        .head_active(head_active), .head_final(head_final),
        .chunk_uops(chunk_uops), .busy(busy)
    );

    steer_group #(
        .UCNT_W(UCNT_W), .CYCLE_CAP(CYCLE_CAP), .OUT_W(OUT_W), .CNT_W(CNT_W)
    ) grp_i (
        .head_active(head_active), .head_final(head_final),
        .head_len_ok(len_ok[0]), .chunk_uops(chunk_uops),
        .follow_ok(simple_ok[2:1]),
        .grant(slot_grant), .consumed(consumed), .uops_out(uops_out)
    );

endmodule

// File: rtl/uop_steer_chk.sv
`timescale 1ns/1ps
module uop_steer_chk #(
    parameter int UCNT_W    = 5,
    parameter int LEN_W     = 4,
    parameter int MAX_LEN   = 7,
    parameter int CPLX_UOPS = 4,
    parameter int CYCLE_CAP = 6,
    parameter int OUT_W     = 3,
    parameter int CNT_W     = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          slot_valid,
    input logic [3*UCNT_W-1:0] slot_uops,
    input logic [3*LEN_W-1:0]  slot_len,
    input logic [2:0]          slot_grant,
    input logic [CNT_W-1:0]    consumed,
    input logic [OUT_W-1:0]    uops_out,
    input logic                busy
);
    // R2
    uops_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uops_out <= OUT_W'(CYCLE_CAP)) && (consumed <= CNT_W'(3)));
    // R4
    grant_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_grant[2] |-> slot_grant[1]) and (slot_grant[1] |-> slot_grant[0]));
    // R4
    simple_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_grant[1] |-> (slot_uops[2*UCNT_W-1:UCNT_W] == UCNT_W'(1)));
    // R5
    long_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_grant[1] |-> ((slot_len[LEN_W-1:0] <= LEN_W'(MAX_LEN))
                           && (slot_len[2*LEN_W-1:LEN_W] <= LEN_W'(MAX_LEN))));
    // R6
    busy_solo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (slot_grant == 3'b001 && consumed == '0
                  && uops_out == OUT_W'(CPLX_UOPS)));
    // R6
    busy_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> slot_grant[0]);
    // R8
    consumed_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (consumed == CNT_W'($countones(slot_grant))));
    // R9
    valid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_grant[2:1] & ~slot_valid[2:1]) == 2'b00);
endmodule

bind uop_decode_steer uop_steer_chk #(
    .UCNT_W(UCNT_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .CPLX_UOPS(CPLX_UOPS),
    .CYCLE_CAP(CYCLE_CAP), .OUT_W(OUT_W), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_uops(slot_uops),
    .slot_len(slot_len), .slot_grant(slot_grant), .consumed(consumed),
    .uops_out(uops_out), .busy(busy)
);

// File: tb/uop_decode_steer_tb_top.sv
`timescale 1ns/1ps
module uop_decode_steer_tb_top;
    localparam int UCNT_W = 5;
    localparam int LEN_W  = 4;

    typedef struct {
        int    g;
        int    c;
        int    n;
        int    b;
        string tag;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [2:0]          slot_valid = '0;
    logic [3*UCNT_W-1:0] slot_uops = '0;
    logic [3*LEN_W-1:0]  slot_len = '0;
    logic [2:0]          slot_grant;
    logic [1:0]          consumed;
    logic [2:0]          uops_out;
    logic                busy;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    int   brem   = 0;
    bit   done   = 1'b0;

    always #2.5 clk = ~clk;

    uop_decode_steer dut_i (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_uops(slot_uops),
        .slot_len(slot_len), .slot_grant(slot_grant), .consumed(consumed),
        .uops_out(uops_out), .busy(busy)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of slot inputs and queues the expected result.
    task automatic drive(input bit [2:0] vv, input int u0, input int u1, input int u2,
                         input int l0, input int l1, input int l2, input string tag);
        exp_t e;
        int   hu;
        bit   g1, g2;
        @(negedge clk);
        slot_valid = vv;
        slot_uops  = {UCNT_W'(u2), UCNT_W'(u1), UCNT_W'(u0)};
        slot_len   = {LEN_W'(l2), LEN_W'(l1), LEN_W'(l0)};
        e = '{g: 0, c: 0, n: 0, b: 0, tag: tag};
        if (brem > 0) hu = brem;
        else if (vv[0]) hu = u0;
        else hu = 0;
        if (hu > 4) begin
            e.g = 1; e.n = 4; e.b = 1; brem = hu - 4;
        end else if (hu > 0) begin
            g1 = (l0 <= 7) && vv[1] && (u1 == 1) && (l1 <= 7);
            g2 = g1 && vv[2] && (u2 == 1) && (l2 <= 7);
            e.g = 1 + 2 * int'(g1) + 4 * int'(g2);
            e.n = hu + int'(g1) + int'(g2);
            e.c = 1 + int'(g1) + int'(g2);
            brem = 0;
        end
        q.push_back(e);
    endtask

    // Monitor: compares one time unit after the inputs settle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "grant", int'(slot_grant), e.g);
                chk(e.tag, "consumed", int'(consumed), e.c);
                chk(e.tag, "uops", int'(uops_out), e.n);
                chk(e.tag, "busy", int'(busy), e.b);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        drive(3'b000, 1, 1, 1, 2, 2, 2, "R1 idle after reset");
        drive(3'b111, 1, 1, 1, 3, 3, 3, "R3 one-one-one");
        drive(3'b111, 4, 1, 1, 7, 7, 7, "R2 four-one-one cap");
        drive(3'b111, 2, 2, 1, 3, 3, 3, "R4 slot1 complex");
        drive(3'b111, 1, 1, 3, 3, 3, 3, "R4 slot2 complex");
        drive(3'b111, 3, 1, 1, 9, 2, 2, "R5 long head");
        drive(3'b111, 1, 1, 1, 2, 8, 2, "R5 long slot1");
        drive(3'b111, 1, 1, 1, 2, 2, 15, "R5 long slot2");
        drive(3'b101, 1, 1, 1, 2, 2, 2, "R9 slot1 invalid");
        drive(3'b110, 1, 1, 1, 2, 2, 2, "R9 head invalid");
        drive(3'b111, 10, 1, 1, 4, 3, 3, "R6 ten chunk a");
        drive(3'b111, 10, 1, 1, 4, 3, 3, "R6 ten chunk b");
        drive(3'b111, 10, 1, 1, 4, 3, 3, "R7 ten final");
        drive(3'b111, 5, 1, 1, 4, 3, 3, "R6 five chunk");
        drive(3'b111, 5, 1, 1, 4, 3, 3, "R7 five final");
        drive(3'b111, 8, 1, 1, 4, 3, 3, "R6 eight chunk");
        drive(3'b111, 8, 1, 1, 4, 3, 3, "R2 eight final cap");
        drive(3'b011, 6, 1, 1, 4, 3, 3, "R6 six chunk");
        drive(3'b011, 6, 1, 1, 4, 3, 3, "R8 six final pair");
        drive(3'b011, 2, 1, 1, 3, 3, 3, "R8 two-one pair");
        drive(3'b001, 4, 1, 1, 3, 3, 3, "R3 head alone");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule